// File: doc/BRIEF.md
# Serial Save-Memory Slave

This block behaves like the byte-serial save chip on a game cartridge. It can act as a serial EEPROM, a 512-byte EEPROM that takes its ninth address bit from the opcode, or a serial flash. A host SPI port hands it one byte per transfer. For each byte the slave returns one response byte. The first byte of a frame is an opcode. The next one to three bytes form an address, sent most significant byte first. Every byte after that is a data byte that reads, writes or exchanges a location of a small internal power-of-two memory.

Framing is a single `frame_start` pulse. The host raises it when chip select is asserted after hold was clear. The pulse empties the opcode latch, so the next byte accepted is taken as a new opcode. A configuration strobe sets the memory size and kind, and these in turn fix the address width.

Bytes enter on a valid/ready stream and responses leave on a second valid/ready stream. A byte is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its response appears, registered, on the next cycle with `out_valid` high, which also serves as the done pulse. `in_ready` drops while a response waits for `out_ready`. Each accepted byte therefore yields exactly one response, and no response is ever lost.

Top module: `spi_save_slave`

## Requirements
- R1: An accepted byte produces its response with `out_valid` high in the next cycle. While `out_valid` is high and `out_ready` is low, `out_byte` holds steady and `in_ready` stays low. `out_valid` never rises without a byte having been accepted.
- R2: Following a `frame_start` pulse, the next byte accepted becomes the opcode and is answered with 0xFF. A byte accepted in the same cycle as the pulse also counts as that opcode.
- R3: Opcodes 0x06, 0x04 and 0x05 act on each byte that follows the opcode byte. Opcode 0x06 sets the write-enable flag, which is bit 1 of the status byte. Opcode 0x04 clears it. Opcode 0x05 answers with the status byte, whose other bits read 0.
- R4: For any other opcode, the next 1, 2 or 3 bytes (set by the address width) shift into the address most significant byte first, and each of them is answered with 0xFF.
- R5: A configuration strobe with size exponent 9 or less selects the 512-byte EEPROM mode with 1 address byte, whatever the flash flag says. An exponent above 16 selects 3 address bytes. Any other exponent selects 2 address bytes, in flash mode if the flash flag is set and in EEPROM mode if it is not. After reset the block is in EEPROM mode with 2 address bytes, the status byte is 0 and the opcode latch is empty.
- R6: In 512-byte EEPROM mode, an opcode with bit 3 set (0x0B read, 0x0A write) loads 1 into the address before the address byte arrives, and that 1 becomes address bit 8.
- R7: In both EEPROM modes, a read (0x03 or 0x0B) masks the address to the memory size, answers with that location and then steps the address by one, so reads wrap around. A write (0x02 or 0x0A) stores the byte and steps the address only while the address is below the size. Otherwise the write does nothing.
- R8: In flash mode, a read (0x03) at or beyond the size answers 0xFF and leaves the address unchanged. Program (0x02) stores the byte and steps the address. Exchange (0x0A) answers with the old contents of the location, stores the new byte and steps the address. Writes at or beyond the size do nothing.
- R9: Unknown opcodes and every write-data byte of 0x02 are answered with 0xFF.
- R10: The memory size is 2 to the power of the configured exponent, limited to the physical array of 2^MEM_AW bytes. Every location reads 0xFF after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Strobe that latches the configuration inputs |
| cfg_flash | input | 1 | Selects flash behaviour for sizes above 512 bytes |
| cfg_size_log2 | input | 5 | Memory size exponent |
| frame_start | input | 1 | Pulse at the start of a frame that empties the opcode latch |
| in_valid | input | 1 | Host byte is valid |
| in_ready | output | 1 | Slave can accept a byte |
| in_byte | input | 8 | Host byte |
| out_valid | output | 1 | Response byte is valid (done pulse) |
| out_ready | input | 1 | Host takes the response |
| out_byte | output | 8 | Response byte |

## Verification
Most faults in the internal state surface as a wrong response byte on the very next byte of the frame. A stale opcode latch answers a new opcode with something other than 0xFF, or treats it as data. An address counter that is off by one, or that wraps at the wrong point, returns data from a neighbouring location on the first read byte after the address phase. A wrong address width moves the boundary between the address phase and the data phase by one byte, so a 0xFF appears where data was expected, or the reverse. A lost write-enable change shows only on the next status read. A write that should have been ignored but corrupted memory shows only when the same location is read back later. For that reason the stimulus always reads locations back after writing them.

// File: rtl/save_pkg.sv
package save_pkg;
  typedef enum logic [1:0] {
    MODE_EEP    = 2'd0,
    MODE_EEP512 = 2'd1,
    MODE_FLASH  = 2'd2
  } save_mode_e;

  localparam logic [7:0] OP_WRITE    = 8'h02;
  localparam logic [7:0] OP_READ     = 8'h03;
  localparam logic [7:0] OP_WEL_CLR  = 8'h04;
  localparam logic [7:0] OP_STATUS   = 8'h05;
  localparam logic [7:0] OP_WEL_SET  = 8'h06;
  localparam logic [7:0] OP_WRITE_HI = 8'h0A;
  localparam logic [7:0] OP_READ_HI  = 8'h0B;
  localparam logic [7:0] IDLE_BYTE   = 8'hFF;
endpackage

// File: rtl/save_cfg_decode.sv
module save_cfg_decode
  import save_pkg::*;
#(
  parameter int MEM_AW = 10,
  parameter int SZW    = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_load,
  input  logic           cfg_flash,
  input  logic [SZW-1:0] cfg_size_log2,
  output save_mode_e     mode,
  output logic [1:0]     aw_bytes,
  output logic [SZW-1:0] size_lg
);
  localparam logic [SZW-1:0] PHYS_LG  = SZW'(MEM_AW);
  localparam logic [SZW-1:0] SMALL_LG = SZW'(9);
  localparam logic [SZW-1:0] MID_LG   = SZW'(16);

  save_mode_e     mode_n;
  logic [1:0]     aw_n;
  logic [SZW-1:0] lg_n;

  always_comb begin
    if (cfg_size_log2 <= SMALL_LG) begin
      mode_n = MODE_EEP512;
      aw_n   = 2'd1;
    end else begin
      mode_n = cfg_flash ? MODE_FLASH : MODE_EEP;
      aw_n   = (cfg_size_log2 > MID_LG) ? 2'd3 : 2'd2;
    end
    lg_n = (cfg_size_log2 > PHYS_LG) ? PHYS_LG : cfg_size_log2;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode     <= MODE_EEP;
      aw_bytes <= 2'd2;
      size_lg  <= PHYS_LG;
    end else if (cfg_load) begin
      mode     <= mode_n;
      aw_bytes <= aw_n;
      size_lg  <= lg_n;
    end
  end
endmodule

// File: rtl/save_mem.sv
module save_mem #(
  parameter int MEM_AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MEM_AW-1:0] addr,
  output logic [7:0]        rd_data,
  input  logic              we,
  input  logic [7:0]        wr_data
);
  localparam int DEPTH = 1 << MEM_AW;

  logic [7:0] cells [DEPTH];

  assign rd_data = cells[addr];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    always_ff @(posedge clk) begin
      if (!rst_n)
        cells[g] <= 8'hFF;
      else if (we && (addr == MEM_AW'(g)))
        cells[g] <= wr_data;
    end
  end
endmodule

// File: rtl/save_cmd_engine.sv
module save_cmd_engine
  import save_pkg::*;
#(
  parameter int MEM_AW = 10,
  parameter int SZW    = 5,
  parameter int ADW    = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  save_mode_e        mode,
  input  logic [1:0]        aw_bytes,
  input  logic [SZW-1:0]    size_lg,
  input  logic              frame_start,
  input  logic              accept,
  input  logic [7:0]        din,
  input  logic [7:0]        mem_rd,
  output logic [MEM_AW-1:0] mem_addr,
  output logic              mem_we,
  output logic [7:0]        mem_wdata,
  output logic [7:0]        resp,
  output logic              cmd_valid,
  output logic              addr_phase,
  output logic              wel
);
  logic [7:0]     cmd, cmd_n;
  logic           cv_n, wel_n;
  logic [ADW-1:0] addr, addr_n;
  logic [1:0]     left, left_n;
  logic [ADW-1:0] mask, eep_addr, sel_addr;
  logic           in_range, is_eep, live_cmd, status_op;

  assign mask      = (ADW'(1) << size_lg) - ADW'(1);
  assign eep_addr  = addr & mask;
  assign in_range  = (addr >> size_lg) == '0;
  assign is_eep    = (mode != MODE_FLASH);
  assign sel_addr  = is_eep ? eep_addr : addr;
  assign mem_addr  = sel_addr[MEM_AW-1:0];
  assign mem_wdata = din;
  assign live_cmd  = cmd_valid && !frame_start;
  assign status_op = (cmd == OP_WEL_CLR) || (cmd == OP_WEL_SET) || (cmd == OP_STATUS);
  assign addr_phase = cmd_valid && (left != 2'd0) && !status_op;

  always_comb begin
    cmd_n  = cmd;
    cv_n   = cmd_valid;
    wel_n  = wel;
    addr_n = addr;
    left_n = left;
    resp   = IDLE_BYTE;
    mem_we = 1'b0;
    if (accept) begin
      if (!live_cmd) begin
        cmd_n  = din;
        cv_n   = 1'b1;
        addr_n = (mode == MODE_EEP512 && din[3]) ? ADW'(1) : '0;
        left_n = aw_bytes;
      end else if (cmd == OP_WEL_CLR) begin
        wel_n = 1'b0;
      end else if (cmd == OP_WEL_SET) begin
        wel_n = 1'b1;
      end else if (cmd == OP_STATUS) begin
        resp = {6'b0, wel, 1'b0};
      end else if (left != 2'd0) begin
        addr_n = {addr[ADW-9:0], din};
        left_n = left - 2'd1;
      end else if (is_eep) begin
        if (cmd == OP_READ || cmd == OP_READ_HI) begin
          resp   = mem_rd;
          addr_n = eep_addr + ADW'(1);
        end else if ((cmd == OP_WRITE || cmd == OP_WRITE_HI) && in_range) begin
          mem_we = 1'b1;
          addr_n = addr + ADW'(1);
        end
      end else begin
        if (cmd == OP_READ && in_range) begin
          resp   = mem_rd;
          addr_n = addr + ADW'(1);
        end else if (cmd == OP_WRITE && in_range) begin
          mem_we = 1'b1;
          addr_n = addr + ADW'(1);
        end else if (cmd == OP_WRITE_HI && in_range) begin
          resp   = mem_rd;
          mem_we = 1'b1;
          addr_n = addr + ADW'(1);
        end
      end
    end else if (frame_start) begin
      cv_n = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd       <= '0;
      cmd_valid <= 1'b0;
      wel       <= 1'b0;
      addr      <= '0;
      left      <= '0;
    end else begin
      cmd       <= cmd_n;
      cmd_valid <= cv_n;
      wel       <= wel_n;
      addr      <= addr_n;
      left      <= left_n;
    end
  end
endmodule

// File: rtl/spi_save_slave.sv
module spi_save_slave
  import save_pkg::*;
#(
  parameter int MEM_AW = 10,
  parameter int SZW    = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_load,
  input  logic           cfg_flash,
  input  logic [SZW-1:0] cfg_size_log2,
  input  logic           frame_start,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [7:0]     in_byte,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [7:0]     out_byte
);
  save_mode_e        mode;
  logic [1:0]        aw_bytes;
  logic [SZW-1:0]    size_lg;
  logic [MEM_AW-1:0] mem_addr;
  logic              mem_we;
  logic [7:0]        mem_wdata, mem_rd, resp;
  logic              cmd_valid, addr_phase, wel, accept;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  save_cfg_decode #(.MEM_AW(MEM_AW), .SZW(SZW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_flash(cfg_flash),
    .cfg_size_log2(cfg_size_log2), .mode(mode), .aw_bytes(aw_bytes), .size_lg(size_lg)
  );

  save_mem #(.MEM_AW(MEM_AW)) u_mem (
    .clk(clk), .rst_n(rst_n), .addr(mem_addr), .rd_data(mem_rd),
    .we(mem_we), .wr_data(mem_wdata)
  );

  save_cmd_engine #(.MEM_AW(MEM_AW), .SZW(SZW)) u_eng (
    .clk(clk), .rst_n(rst_n), .mode(mode), .aw_bytes(aw_bytes), .size_lg(size_lg),
    .frame_start(frame_start), .accept(accept), .din(in_byte), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .resp(resp),
    .cmd_valid(cmd_valid), .addr_phase(addr_phase), .wel(wel)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_byte  <= 8'hFF;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_byte  <= resp;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_save_slave_chk.sv
module spi_save_slave_chk #(
  parameter int SZW = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cfg_load,
  input logic [SZW-1:0] cfg_size_log2,
  input logic           frame_start,
  input logic           in_valid,
  input logic           in_ready,
  input logic           out_valid,
  input logic           out_ready,
  input logic [7:0]     out_byte,
  input logic           cmd_valid,
  input logic           addr_phase,
  input logic [1:0]     aw_bytes
);
  assert_rise_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready));

  assert_hold_on_stall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte)));

  assert_stall_blocks_input_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_frame_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !(in_valid && in_ready)) |=> !cmd_valid);

  assert_opcode_answer_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (!cmd_valid || frame_start)) |=> (cmd_valid && out_byte == 8'hFF));

  assert_addr_phase_ff_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !frame_start && addr_phase) |=> (out_byte == 8'hFF));

  assert_small_cfg_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_load && cfg_size_log2 <= SZW'(9)) |=> (aw_bytes == 2'd1));

  assert_large_cfg_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_load && cfg_size_log2 > SZW'(16)) |=> (aw_bytes == 2'd3));
endmodule

bind spi_save_slave spi_save_slave_chk #(.SZW(SZW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_size_log2(cfg_size_log2),
  .frame_start(frame_start), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte),
  .cmd_valid(cmd_valid), .addr_phase(addr_phase), .aw_bytes(aw_bytes)
);

// File: tb/tb_spi_save_slave.sv
`timescale 1ns/1ps
module tb_spi_save_slave;
  localparam int MAW = 10;
  localparam int DEPTH = 1 << MAW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_load = 1'b0, cfg_flash = 1'b0;
  logic [4:0] cfg_size_log2 = 5'd0;
  logic frame_start = 1'b0, in_valid = 1'b0, out_ready = 1'b1;
  logic [7:0] in_byte = 8'h00;
  logic in_ready, out_valid;
  logic [7:0] out_byte;

  int total = 0, bad = 0;
  bit done = 1'b0;

  // reference state, from the requirements
  int m_mode;            // 0 eeprom, 1 eeprom512, 2 flash
  int m_aw, m_lg, m_addr, m_left;
  bit m_cv, m_wel;
  logic [7:0] m_cmd;
  logic [7:0] m_mem [DEPTH];

  always #4 clk = ~clk;

  spi_save_slave #(.MEM_AW(MAW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_flash(cfg_flash),
    .cfg_size_log2(cfg_size_log2), .frame_start(frame_start), .in_valid(in_valid),
    .in_ready(in_ready), .in_byte(in_byte), .out_valid(out_valid),
    .out_ready(out_ready), .out_byte(out_byte)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model(input logic [7:0] d);
    int size, a;
    logic [7:0] r;
    r = 8'hFF;
    size = 1 << m_lg;
    if (!m_cv) begin
      m_cmd = d; m_cv = 1'b1; m_left = m_aw;
      m_addr = (m_mode == 1 && d[3]) ? 1 : 0;
    end else if (m_cmd == 8'h04) m_wel = 1'b0;
    else if (m_cmd == 8'h06) m_wel = 1'b1;
    else if (m_cmd == 8'h05) r = {6'b0, m_wel, 1'b0};
    else if (m_left > 0) begin
      m_addr = ((m_addr << 8) | int'(d)) & 32'hFFFFFF; m_left--;
    end else if (m_mode != 2) begin
      if (m_cmd == 8'h03 || m_cmd == 8'h0B) begin
        a = m_addr % size; r = m_mem[a]; m_addr = a + 1;
      end else if ((m_cmd == 8'h02 || m_cmd == 8'h0A) && m_addr < size) begin
        m_mem[m_addr] = d; m_addr++;
      end
    end else if (m_addr < size) begin
      if (m_cmd == 8'h03) begin r = m_mem[m_addr]; m_addr++; end
      else if (m_cmd == 8'h02) begin m_mem[m_addr] = d; m_addr++; end
      else if (m_cmd == 8'h0A) begin r = m_mem[m_addr]; m_mem[m_addr] = d; m_addr++; end
    end
    return r;
  endfunction

  task automatic send(input logic [7:0] d, input string req);
    logic [7:0] e;
    @(negedge clk);
    in_valid = 1'b1; in_byte = d;
    e = model(d);
    @(negedge clk);
    in_valid = 1'b0;
    total++;
    if (out_valid !== 1'b1) begin
      bad++;
      $display("FAIL %s out_valid actual=%b expected=1", req, out_valid);
    end
    check(req, out_byte, e);
  endtask

  task automatic frame();
    @(negedge clk);
    frame_start = 1'b1; m_cv = 1'b0;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic configure(input bit fl, input int lg);
    @(negedge clk);
    cfg_load = 1'b1; cfg_flash = fl; cfg_size_log2 = 5'(lg);
    if (lg <= 9) begin m_mode = 1; m_aw = 1; end
    else begin m_mode = fl ? 2 : 0; m_aw = (lg > 16) ? 3 : 2; end
    m_lg = (lg > MAW) ? MAW : lg;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    logic [7:0] e;
    int unused_seed;
    unused_seed = $urandom(32'h5A17);
    m_mode = 0; m_aw = 2; m_lg = MAW; m_addr = 0; m_left = 0; m_cv = 0; m_wel = 0; m_cmd = 0;
    for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R5 reset state
    check("R1 reset out_valid", {7'b0, out_valid}, 8'h00);
    check("R1 reset in_ready", {7'b0, in_ready}, 8'h01);
    frame(); send(8'h05, "R2 opcode"); send(8'h00, "R5 reset status zero");
    // R3 write-enable set, clear
    frame(); send(8'h06, "R2 opcode"); send(8'h00, "R3 set");
    frame(); send(8'h05, "R2"); send(8'h00, "R3 status wel"); check("R3 wel value", out_byte, 8'h02);
    frame(); send(8'h04, "R2"); send(8'h00, "R3 clear");
    frame(); send(8'h05, "R2"); send(8'h00, "R3 status cleared");
    // R5 default 2-byte address, R10 erased, R4, R7
    frame(); send(8'h03, "R2"); send(8'h00, "R4 addr"); send(8'h40, "R4 addr");
    send(8'h00, "R10 erased read");
    configure(1'b0, 10);
    frame(); send(8'h02, "R2"); send(8'h00, "R4"); send(8'h10, "R4");
    send(8'hAA, "R9 write data"); send(8'hBB, "R9 write data");
    frame(); send(8'h03, "R2"); send(8'h00, "R4"); send(8'h10, "R4");
    send(8'h00, "R7 read"); send(8'h00, "R7 read next"); check("R7 value", out_byte, 8'hBB);
    // R7 wrap and ignored write past end
    frame(); send(8'h02, "R2"); send(8'h03, "R4"); send(8'hFF, "R4");
    send(8'h11, "R7 last"); send(8'h22, "R7 past end ignored");
    frame(); send(8'h03, "R2"); send(8'h03, "R4"); send(8'hFF, "R4");
    send(8'h00, "R7 read last"); send(8'h00, "R7 wrap to zero"); check("R7 wrap value", out_byte, 8'hFF);
    // R6 512-byte mode
    configure(1'b1, 9);
    frame(); send(8'h0A, "R2"); send(8'h05, "R4"); send(8'h77, "R6 write high");
    frame(); send(8'h0B, "R2"); send(8'h05, "R4"); send(8'h00, "R6 read high"); check("R6 value", out_byte, 8'h77);
    frame(); send(8'h03, "R2"); send(8'h05, "R4"); send(8'h00, "R6 low half untouched");
    // R8 flash
    configure(1'b1, 10);
    frame(); send(8'h02, "R2"); send(8'h00, "R4"); send(8'h20, "R4"); send(8'h5C, "R8 program");
    frame(); send(8'h0A, "R2"); send(8'h00, "R4"); send(8'h20, "R4"); send(8'hC5, "R8 exchange old");
    check("R8 exchange value", out_byte, 8'h5C);
    frame(); send(8'h03, "R2"); send(8'h00, "R4"); send(8'h20, "R4"); send(8'h00, "R8 exchange stored");
    frame(); send(8'h03, "R2"); send(8'h04, "R4"); send(8'h00, "R4"); send(8'h00, "R8 read past end");
    // R5 three address bytes, R9 unknown
    configure(1'b1, 17);
    frame(); send(8'h03, "R2"); send(8'h00, "R4 b0"); send(8'h00, "R4 b1"); send(8'h20, "R4 b2");
    send(8'h00, "R5 24-bit read");
    frame(); send(8'h9F, "R2"); send(8'h00, "R9 unknown"); send(8'h00, "R9 unknown");
    // R2 byte in same cycle as frame_start is the opcode
    @(negedge clk);
    frame_start = 1'b1; in_valid = 1'b1; in_byte = 8'h05; m_cv = 1'b0; e = model(8'h05);
    @(negedge clk);
    frame_start = 1'b0; in_valid = 1'b0;
    check("R2 same-cycle opcode", out_byte, e);
    send(8'h00, "R2 status follows");
    // R1 back-pressure
    frame(); send(8'h05, "R2");
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_byte = 8'h00; e = model(8'h00);
    @(negedge clk);
    in_valid = 1'b0; held = out_byte;
    check("R1 stalled response", out_byte, e);
    repeat (2) @(negedge clk);
    check("R1 held valid", {7'b0, out_valid}, 8'h01);
    check("R1 held byte", out_byte, held);
    check("R1 input blocked", {7'b0, in_ready}, 8'h00);
    out_ready = 1'b1;
    @(negedge clk);
    check("R1 released", {7'b0, out_valid}, 8'h00);
    // random frames
    for (int f = 0; f < 400; f++) begin
      logic [7:0] ops [8];
      int n;
      ops = '{8'h02, 8'h03, 8'h0A, 8'h0B, 8'h04, 8'h05, 8'h06, 8'h9F};
      if (($urandom % 20) == 0) begin
        int lgs [4];
        lgs = '{8, 9, 10, 17};
        configure(1'($urandom), lgs[$urandom % 4]);
      end
      frame();
      send(ops[$urandom % 8], "R2 random opcode");
      n = 1 + ($urandom % 7);
      for (int b = 0; b < n; b++) begin
        logic [7:0] d;
        d = 8'($urandom);
        if (b < m_aw && (($urandom % 2) == 0)) d = d & 8'h03;
        send(d, "R7 R8 random byte");
      end
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule